// File: doc/BRIEF.md
# Multiplier-Free Gaussian Noise Generator

This block emits approximately Gaussian white noise samples for use in channel emulation, and it contains no multiplier. On each enabled cycle two free-running pseudo-random registers step together: a 32-bit linear feedback shift register and a 32-cell cellular automaton that mixes rule 90 and rule 150 cells. The top 12 bits of each register are XORed to form one uniform word. Each word goes into a 16-slot shuffle buffer in write order. A separate 8-bit LFSR picks the slot to read, so the words leave the buffer in scrambled order and lose part of their correlation.

Twelve shuffled words are added to form one output sample. The constant mean, 12 x 2048, is subtracted so the result is centred on zero, and an arithmetic left shift set by a 4-bit energy code scales it. The seeds are loaded through a load strobe and the energy code is read live, so both can change at run time.

Top module: `gng_top`

## Requirements
- R1: During and right after reset, `noise` is 0 and `noise_valid` is 0.
- R2: After a seed load, the first `noise_valid` pulse follows the 28th enabled cycle: 16 cycles to fill the buffer, then 12 accumulation cycles. Each later pulse follows every further 12 enabled cycles. A pulse lasts one cycle.
- R3: A cycle with `enable` low changes nothing. No pulse is produced, `noise` is held, and the sample sequence and its enabled-cycle positions equal those of a run with no gaps.
- R4: A load cycle takes priority over `enable`. Loading the same seeds always reproduces the same sample sequence, whether or not `enable` was high during the load.
- R5: A sample equals the centred sum shifted left by the `energy` value present in the cycle that completes it. Energy code e gives exactly the energy-0 sample times 2^e.
- R6: With `energy` = 0, every sample lies in the range -24576 to 24564. This is the sum of twelve 12-bit words less 24576.
- R7: A zero LFSR seed is loaded as 32'h00000001 and a zero automaton seed as 32'h9E3779B9. Seeds (0,0) therefore give the same sequence as seeds (1, 32'h9E3779B9), and that sequence is not constant.
- R8: Loading different seeds at run time changes the produced sequence.
- R9: With `energy` = 0, 64 consecutive samples include both positive and negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Loads the seeds and restarts buffer fill and accumulation |
| seed_lfsr | input | 32 | Seed for the 32-bit LFSR |
| seed_ca | input | 32 | Seed for the cellular automaton |
| energy | input | 4 | Left-shift amount applied to the centred sum |
| enable | input | 1 | Advances the generator by one step |
| noise | output | 32 | Signed noise sample, held between pulses |
| noise_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The buffer fill counter and the accumulation counter set the pulse positions. If either is wrong, the first pulse moves away from enabled cycle 28 or the 12-cycle spacing breaks, and this shows within the first 40 enabled cycles after a load. A wrong shift-register step, read index or seed substitution changes the sample values. Comparing against a reference sequence from the same seeds shows such a fault on the first sample. A wrong offset or scaling pushes samples outside the energy-0 range or breaks the exact 2^e ratio on the first affected sample.

// File: rtl/gng_pkg.sv
package gng_pkg;
    localparam int unsigned DEF_REG_W   = 32;
    localparam int unsigned DEF_UNI_W   = 12;
    localparam int unsigned DEF_NSUM    = 12;
    localparam int unsigned DEF_DEPTH   = 16;
    localparam int unsigned DEF_IDX_W   = 8;
    localparam int unsigned DEF_ENG_W   = 4;
    localparam int unsigned DEF_OUT_W   = 32;

    // Galois masks (right-shifting form) and automaton rule choice
    localparam logic [31:0] DEF_LFSR_MASK = 32'h8020_0003;
    localparam logic [31:0] DEF_CA_RULE   = 32'h0000_0005; // 1 = rule 150 cell
    localparam logic [31:0] DEF_LFSR_SUB  = 32'h0000_0001;
    localparam logic [31:0] DEF_CA_SUB    = 32'h9E37_79B9;
    localparam logic [7:0]  DEF_IDX_MASK  = 8'hB8;
    localparam logic [7:0]  DEF_IDX_SUB   = 8'h01;

    typedef enum logic [0:0] {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } fill_phase_e;

    // replaces a zero seed with a fixed nonzero constant
    function automatic logic [63:0] nz_seed(input logic [63:0] seed,
                                            input logic [63:0] sub);
        return (seed == '0) ? sub : seed;
    endfunction
endpackage

// File: rtl/gng_lfsr.sv
module gng_lfsr #(
    parameter int unsigned W    = gng_pkg::DEF_REG_W,
    parameter logic [W-1:0] MASK = W'(gng_pkg::DEF_LFSR_MASK),
    parameter logic [W-1:0] SUB  = W'(gng_pkg::DEF_LFSR_SUB)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.sr = W'(gng_pkg::nz_seed(64'(seed), 64'(SUB)));
        end else if (step) begin
            nxt_d.sr = (cur_q.sr >> 1) ^ (cur_q.sr[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{sr: SUB};
        else        cur_q <= nxt_d;
    end

    assign state = cur_q.sr;
endmodule

// File: rtl/gng_ca.sv
module gng_ca #(
    parameter int unsigned W    = gng_pkg::DEF_REG_W,
    parameter logic [W-1:0] RULE = W'(gng_pkg::DEF_CA_RULE),
    parameter logic [W-1:0] SUB  = W'(gng_pkg::DEF_CA_SUB)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);
    typedef struct packed {
        logic [W-1:0] cells;
    } ca_st_t;

    ca_st_t       cur_q, nxt_d;
    logic [W-1:0] evolved;

    // null-boundary neighbourhood update, one cell per generate slice
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic left_n, right_n;
        if (i == 0) begin : g_lo
            assign right_n = 1'b0;
        end else begin : g_lo
            assign right_n = cur_q.cells[i-1];
        end
        if (i == W-1) begin : g_hi
            assign left_n = 1'b0;
        end else begin : g_hi
            assign left_n = cur_q.cells[i+1];
        end
        assign evolved[i] = left_n ^ right_n ^ (RULE[i] & cur_q.cells[i]);
    end

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.cells = W'(gng_pkg::nz_seed(64'(seed), 64'(SUB)));
        end else if (step) begin
            nxt_d.cells = evolved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{cells: SUB};
        else        cur_q <= nxt_d;
    end

    assign state = cur_q.cells;
endmodule

// File: rtl/gng_shuffle.sv
module gng_shuffle #(
    parameter int unsigned DW        = gng_pkg::DEF_UNI_W,
    parameter int unsigned DEPTH     = gng_pkg::DEF_DEPTH,
    parameter int unsigned IDX_W     = gng_pkg::DEF_IDX_W,
    parameter logic [IDX_W-1:0] IDX_MASK = IDX_W'(gng_pkg::DEF_IDX_MASK),
    parameter logic [IDX_W-1:0] IDX_SUB  = IDX_W'(gng_pkg::DEF_IDX_SUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] idx_seed,
    input  logic             step,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic             full
);
    import gng_pkg::*;

    localparam int unsigned PTR_W  = $clog2(DEPTH);
    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]         wr_ptr;
        logic [FILL_W-1:0]        fill;
        fill_phase_e              phase;
        logic [IDX_W-1:0]         idx;
    } shuf_st_t;

    shuf_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.wr_ptr = '0;
            nxt_d.fill   = '0;
            nxt_d.phase  = PH_FILL;
            nxt_d.idx    = IDX_W'(nz_seed(64'(idx_seed), 64'(IDX_SUB)));
        end else if (step) begin
            nxt_d.mem[cur_q.wr_ptr] = wr_data;
            nxt_d.wr_ptr = (cur_q.wr_ptr == PTR_W'(DEPTH-1)) ? '0 : cur_q.wr_ptr + 1'b1;
            if (cur_q.phase == PH_FILL) begin
                nxt_d.fill = cur_q.fill + 1'b1;
                if (cur_q.fill == FILL_W'(DEPTH-1)) nxt_d.phase = PH_RUN;
            end else begin
                nxt_d.idx = (cur_q.idx >> 1) ^ (cur_q.idx[0] ? IDX_MASK : '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.idx    <= IDX_SUB;
            cur_q.phase  <= PH_FILL;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_data = cur_q.mem[cur_q.idx[PTR_W-1:0]];
    assign full    = (cur_q.phase == PH_RUN);
endmodule

// File: rtl/gng_top.sv
module gng_top #(
    parameter int unsigned REG_W = gng_pkg::DEF_REG_W,
    parameter int unsigned UNI_W = gng_pkg::DEF_UNI_W,
    parameter int unsigned NSUM  = gng_pkg::DEF_NSUM,
    parameter int unsigned DEPTH = gng_pkg::DEF_DEPTH,
    parameter int unsigned IDX_W = gng_pkg::DEF_IDX_W,
    parameter int unsigned ENG_W = gng_pkg::DEF_ENG_W,
    parameter int unsigned OUT_W = gng_pkg::DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] seed_lfsr,
    input  logic [REG_W-1:0] seed_ca,
    input  logic [ENG_W-1:0] energy,
    input  logic             enable,
    output logic [OUT_W-1:0] noise,
    output logic             noise_valid
);
    import gng_pkg::*;

    localparam int unsigned ACC_W  = UNI_W + $clog2(NSUM);
    localparam int unsigned SUM_W  = ACC_W + 1;
    localparam int unsigned CNT_W  = $clog2(NSUM);
    localparam logic [SUM_W-1:0] OFFSET = SUM_W'(NSUM) << (UNI_W - 1);
    localparam logic [REG_W-1:0] LSUB = REG_W'(DEF_LFSR_SUB);
    localparam logic [REG_W-1:0] CSUB = REG_W'(DEF_CA_SUB);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [OUT_W-1:0] noise;
        logic             valid;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    logic [REG_W-1:0] lfsr_word, ca_word;
    logic [UNI_W-1:0] uni_word, shuf_word;
    logic [IDX_W-1:0] idx_seed;
    logic             buf_full, step;
    logic [ACC_W-1:0] acc_sum;
    logic signed [SUM_W-1:0] centred;
    logic signed [OUT_W-1:0] centred_ext;

    assign step     = enable & ~load;
    assign uni_word = lfsr_word[REG_W-1 -: UNI_W] ^ ca_word[REG_W-1 -: UNI_W];
    assign idx_seed = IDX_W'(nz_seed(64'(seed_lfsr), 64'(LSUB)))
                    ^ IDX_W'(nz_seed(64'(seed_ca),   64'(CSUB)));

    gng_lfsr #(.W(REG_W), .MASK(REG_W'(DEF_LFSR_MASK)), .SUB(LSUB)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_lfsr),
        .step(step), .state(lfsr_word)
    );

    gng_ca #(.W(REG_W), .RULE(REG_W'(DEF_CA_RULE)), .SUB(CSUB)) u_ca (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed_ca),
        .step(step), .state(ca_word)
    );

    gng_shuffle #(
        .DW(UNI_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
        .IDX_MASK(IDX_W'(DEF_IDX_MASK)), .IDX_SUB(IDX_W'(DEF_IDX_SUB))
    ) u_shuf (
        .clk(clk), .rst_n(rst_n), .load(load), .idx_seed(idx_seed),
        .step(step), .wr_data(uni_word), .rd_data(shuf_word), .full(buf_full)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        acc_sum     = cur_q.acc + ACC_W'(shuf_word);
        centred     = $signed({1'b0, acc_sum}) - $signed(OFFSET);
        centred_ext = {{(OUT_W-SUM_W){centred[SUM_W-1]}}, centred};
        if (load) begin
            nxt_d.acc = '0;
            nxt_d.cnt = '0;
        end else if (step && buf_full) begin
            if (cur_q.cnt == CNT_W'(NSUM-1)) begin
                nxt_d.acc   = '0;
                nxt_d.cnt   = '0;
                nxt_d.valid = 1'b1;
                nxt_d.noise = centred_ext <<< energy;
            end else begin
                nxt_d.acc = acc_sum;
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign noise       = cur_q.noise;
    assign noise_valid = cur_q.valid;
endmodule

// File: rtl/gng_chk.sv
module gng_chk #(
    parameter int unsigned REG_W = 32,
    parameter int unsigned UNI_W = 12,
    parameter int unsigned NSUM  = 12,
    parameter int unsigned ENG_W = 4,
    parameter int unsigned OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             enable,
    input logic [ENG_W-1:0] energy,
    input logic [OUT_W-1:0] noise,
    input logic             noise_valid,
    input logic [REG_W-1:0] lfsr_word,
    input logic [REG_W-1:0] ca_word
);
    localparam longint LO = -(longint'(NSUM) << (UNI_W - 1));
    localparam longint HI = (longint'(NSUM) * ((longint'(1) << UNI_W) - 1)) + LO;

    // R2: a sample marker is never longer than one cycle
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        noise_valid |=> !noise_valid);

    // R3, R4: a marker only follows a non-load enabled cycle
    assert_valid_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        noise_valid |-> $past(enable && !load));

    // R3: output held between markers
    assert_hold_noise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_valid |-> $stable(noise));

    // R6: unscaled samples stay inside the centred range
    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_valid && $past(energy) == '0) |->
        ($signed(noise) >= LO && $signed(noise) <= HI));

    // R7: neither shift register can sit in the all-zero state
    assert_no_lockup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_word != '0) && (ca_word != '0));
endmodule

bind gng_top gng_chk #(
    .REG_W(REG_W), .UNI_W(UNI_W), .NSUM(NSUM), .ENG_W(ENG_W), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .enable(enable), .energy(energy),
    .noise(noise), .noise_valid(noise_valid),
    .lfsr_word(lfsr_word), .ca_word(ca_word)
);

// File: tb/gng_top_tb.sv
module gng_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] seed_lfsr = '0;
    logic [31:0] seed_ca = '0;
    logic [3:0]  energy = '0;
    logic        enable = 1'b0;
    logic [31:0] noise;
    logic        noise_valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic signed [31:0] smp [64];
    int                 eidx [64];
    logic signed [31:0] ref_s [64];
    int                 ref_e [64];

    localparam logic [31:0] SA = 32'h1234_5678;
    localparam logic [31:0] SB = 32'hCAFE_0F0F;

    always #2 clk = ~clk;

    gng_top u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .seed_lfsr(seed_lfsr),
        .seed_ca(seed_ca), .energy(energy), .enable(enable),
        .noise(noise), .noise_valid(noise_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] a, input logic [31:0] b, input bit en);
        @(negedge clk);
        load = 1'b1; seed_lfsr = a; seed_ca = b; enable = en;
        @(negedge clk);
        load = 1'b0; enable = 1'b0;
    endtask

    task automatic collect(input int n, input bit gaps);
        int got = 0;
        int edges = 0;
        int cyc = 0;
        int held_bad = 0;
        logic [31:0] last = noise;
        while (got < n) begin
            @(negedge clk);
            enable = gaps ? ((cyc % 3) != 2) : 1'b1;
            cyc++;
            @(posedge clk);
            #1;
            if (enable) edges++;
            if (noise_valid) begin
                if (!enable) held_bad++;
                smp[got] = noise;
                eidx[got] = edges;
                got++;
            end else if (noise !== last) begin
                held_bad++;
            end
            last = noise;
        end
        @(negedge clk);
        enable = 1'b0;
        check(held_bad == 0, "R3", "output held between markers", held_bad, 0);
    endtask

    task automatic save_ref(input int n);
        for (int i = 0; i < n; i++) begin
            ref_s[i] = smp[i];
            ref_e[i] = eidx[i];
        end
    endtask

    task automatic t_reset();
        check(noise_valid == 1'b0, "R1", "valid in reset", noise_valid, 0);
        check(noise == '0, "R1", "noise in reset", noise, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(noise_valid == 1'b0 && noise == '0, "R1", "state after reset", noise, 0);
    endtask

    task automatic t_cadence();
        int bad_gap = 0;
        energy = 4'd0;
        do_load(SA, SB, 1'b0);
        collect(6, 1'b0);
        check(eidx[0] == 28, "R2", "first sample position", eidx[0], 28);
        for (int i = 1; i < 6; i++)
            if (eidx[i] - eidx[i-1] != 12) bad_gap++;
        check(bad_gap == 0, "R2", "sample spacing errors", bad_gap, 0);
        save_ref(6);
    endtask

    task automatic t_gaps();
        int diff = 0;
        do_load(SA, SB, 1'b0);
        collect(6, 1'b1);
        for (int i = 0; i < 6; i++)
            if (smp[i] !== ref_s[i] || eidx[i] != ref_e[i]) diff++;
        check(diff == 0, "R3", "gapped run mismatches", diff, 0);
    endtask

    task automatic t_repeat();
        int diff = 0;
        do_load(SA, SB, 1'b1);
        collect(6, 1'b0);
        for (int i = 0; i < 6; i++)
            if (smp[i] !== ref_s[i]) diff++;
        check(diff == 0, "R4", "reload with enable high mismatches", diff, 0);
        check(eidx[0] == 28, "R4", "load cycle did not step", eidx[0], 28);
    endtask

    task automatic t_energy(input logic [3:0] e);
        energy = e;
        do_load(SA, SB, 1'b0);
        collect(6, 1'b0);
        for (int i = 0; i < 6; i++) begin
            logic signed [31:0] exp_v = ref_s[i] <<< e;
            check(smp[i] === exp_v, "R5", "scaled sample", smp[i], exp_v);
        end
        energy = 4'd0;
    endtask

    task automatic t_range();
        int out_rng = 0;
        int pos = 0;
        int neg = 0;
        energy = 4'd0;
        do_load(32'hA5A5_0001, 32'h0BAD_F00D, 1'b0);
        collect(64, 1'b0);
        for (int i = 0; i < 64; i++) begin
            if (smp[i] < -24576 || smp[i] > 24564) out_rng++;
            if (smp[i] > 0) pos++;
            if (smp[i] < 0) neg++;
        end
        check(out_rng == 0, "R6", "samples out of range", out_rng, 0);
        check(pos > 0, "R9", "positive samples", pos, 1);
        check(neg > 0, "R9", "negative samples", neg, 1);
    endtask

    task automatic t_zero_seed();
        int diff = 0;
        int distinct = 0;
        do_load(32'h0, 32'h0, 1'b0);
        collect(8, 1'b0);
        save_ref(8);
        for (int i = 1; i < 8; i++)
            if (ref_s[i] !== ref_s[0]) distinct++;
        check(distinct > 0, "R7", "zero seed gives varying output", distinct, 1);
        do_load(32'h0000_0001, 32'h9E37_79B9, 1'b0);
        collect(8, 1'b0);
        for (int i = 0; i < 8; i++)
            if (smp[i] !== ref_s[i]) diff++;
        check(diff == 0, "R7", "substituted seed mismatches", diff, 0);
    endtask

    task automatic t_seeds();
        int diff = 0;
        do_load(SA, SB, 1'b0);
        collect(8, 1'b0);
        save_ref(8);
        do_load(SA ^ 32'h1, SB, 1'b0);
        collect(8, 1'b0);
        for (int i = 0; i < 8; i++)
            if (smp[i] !== ref_s[i]) diff++;
        check(diff > 0, "R8", "samples differing after new seed", diff, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_cadence();
        t_gaps();
        t_repeat();
        t_energy(4'd5);
        t_energy(4'd15);
        t_range();
        t_zero_seed();
        t_seeds();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule